// File: doc/BRIEF.md
# Display List Entry Walker

The walker reads display lists held in a 256-word on-chip list memory and produces, for each of three output channels, a stream of plane entries for a downstream compositor. Every entry begins with a header word. The header holds a length in words and a terminator flag. The walker reads a header, sends that header together with its word address and length downstream, and then jumps ahead by the length to reach the next header. It stops when it reads a header with the terminator flag set. It also stops on two malformed cases: a zero length, and a header whose successor would lie past the last memory word.

Software fills the list memory through a simple write port. For each channel it also sets a start pointer, a two-bit mode and an enable. A frame-start pulse latches these settings and restarts every channel. The channels that are walking share the single memory read port in round-robin order, with at most one header read per cycle. Entries leave through one valid/ready output slot.

Top module: `dlist_walker`

## Requirements
- R1: On a frame-start pulse each channel latches its pointer, mode and enable, and its walk begins at the latched pointer. Changes to the pointer between frame-start pulses have no effect until the next pulse.
- R2: Mode encoding: 2'b00 off, 2'b01 run, 2'b10 run, 2'b11 end-of-frame. A channel walks only when its enable is 1 and its mode is run. Otherwise it emits no entries, and its busy flag is 0 from the cycle after the pulse.
- R3: Bit 31 of a header is the terminator. Reading a header with this bit set ends that channel's walk, and no entry is emitted for that header.
- R4: Bits 29:24 of a header are the entry length in words. An entry is emitted with its channel number, its header address, its length and the full header word. The next header is read at the header address plus the length.
- R5: A header with length zero ends the walk without emitting an entry and sets the channel's error flag. The error flag holds until the next frame-start pulse, which clears it.
- R6: When the header address plus the length exceeds 255, the walk ends without emitting an entry and the error flag is set. No read ever goes past word 255.
- R7: Busy channels are served in round-robin order, starting with channel 0 after each frame-start pulse. When every channel has entries, the emitted channel numbers follow 0,1,2,0,1,2.
- R8: While ent_valid is 1 and ent_ready is 0, the entry outputs hold stable. No entry is lost or repeated under backpressure.
- R9: A write on the write port stores wr_data at wr_addr, and later header reads return the stored value.
- R10: After reset, ent_valid, chan_busy and chan_err are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | List memory write strobe |
| wr_addr | input | 8 | List memory word address |
| wr_data | input | 32 | List memory write data |
| frame_start | input | 1 | Latch channel settings and restart walks |
| cfg_en | input | 3 | Per-channel enable |
| cfg_mode | input | 6 | Per-channel mode, 2 bits each |
| cfg_ptr | input | 24 | Per-channel list start address, 8 bits each |
| ent_valid | output | 1 | Entry slot holds an entry |
| ent_ready | input | 1 | Consumer accepts the entry |
| ent_chan | output | 2 | Channel of the entry |
| ent_addr | output | 8 | Word address of the entry header |
| ent_size | output | 6 | Entry length in words |
| ent_hdr | output | 32 | Entry header word |
| chan_busy | output | 3 | Channel walk in progress |
| chan_err | output | 3 | Channel list was malformed this frame |

## Verification
A corrupted per-channel read pointer shows up at the ports within one round-robin turn, at most three header reads later. It appears as a wrong ent_addr or ent_hdr on that channel's next entry, and the scoreboard catches it against a walk of the shadow memory. A busy flag that drops too early or too late shows up as missing or extra entries once all channels go idle. A wrong arbitration pointer breaks the 0,1,2 order of the first six entries. A lost stall shows up as a skipped entry or a duplicated entry in the stream.

// File: rtl/dlist_pkg.sv
package dlist_pkg;
    localparam int HDR_TERM_BIT = 31;
    localparam int HDR_LEN_LSB  = 24;
    localparam int HDR_LEN_W    = 6;

    typedef enum logic [1:0] {
        MD_OFF  = 2'b00,
        MD_RUN  = 2'b01,
        MD_RUN2 = 2'b10,
        MD_EOF  = 2'b11
    } mode_e;

    function automatic logic mode_walks(input logic [1:0] m);
        return (m == MD_RUN) || (m == MD_RUN2);
    endfunction
endpackage

// File: rtl/dlist_mem.sv
module dlist_mem #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) store_q[wr_addr] <= wr_data;
    end

    assign rd_data = store_q[rd_addr];
endmodule

// File: rtl/dlist_rr_arb.sv
module dlist_rr_arb #(
    parameter int N = 3,
    localparam int CW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    input  logic [CW-1:0] last,
    output logic          gnt_vld,
    output logic [CW-1:0] gnt_idx
);
    always_comb begin
        int idx;
        gnt_vld = 1'b0;
        gnt_idx = '0;
        // Scan from farthest to nearest so the nearest request after last wins.
        for (int k = N; k >= 1; k--) begin
            idx = (int'(last) + k) % N;
            if (req[idx]) begin
                gnt_vld = 1'b1;
                gnt_idx = CW'(idx);
            end
        end
    end
endmodule

// File: rtl/dlist_walker.sv
module dlist_walker
    import dlist_pkg::*;
#(
    parameter int NCH    = 3,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1,
    localparam int LEN_W = HDR_LEN_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  frame_start,
    input  logic [NCH-1:0]        cfg_en,
    input  logic [2*NCH-1:0]      cfg_mode,
    input  logic [NCH*ADDR_W-1:0] cfg_ptr,
    output logic                  ent_valid,
    input  logic                  ent_ready,
    output logic [CH_W-1:0]       ent_chan,
    output logic [ADDR_W-1:0]     ent_addr,
    output logic [LEN_W-1:0]      ent_size,
    output logic [DATA_W-1:0]     ent_hdr,
    output logic [NCH-1:0]        chan_busy,
    output logic [NCH-1:0]        chan_err
);
    localparam int DEPTH = 1 << ADDR_W;

    typedef struct packed {
        logic [NCH-1:0]             busy;
        logic [NCH-1:0]             err;
        logic [NCH-1:0][ADDR_W-1:0] cur;
        logic [CH_W-1:0]            last;
        logic                       ovld;
        logic [CH_W-1:0]            ochan;
        logic [ADDR_W-1:0]          oaddr;
        logic [LEN_W-1:0]           olen;
        logic [DATA_W-1:0]          ohdr;
    } walk_st_t;

    walk_st_t st_d, st_q;

    logic              arb_vld;
    logic [CH_W-1:0]   arb_idx;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              rd_go;

    dlist_rr_arb #(.N(NCH)) u_arb (
        .req     (st_q.busy),
        .last    (st_q.last),
        .gnt_vld (arb_vld),
        .gnt_idx (arb_idx)
    );

    assign rd_addr = st_q.cur[arb_idx];

    dlist_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign rd_go = arb_vld && !frame_start && (!st_q.ovld || ent_ready);

    always_comb begin
        logic [LEN_W-1:0] len;
        logic [ADDR_W:0]  nxt;
        int               c;
        st_d = st_q;
        len  = rd_data[HDR_LEN_LSB +: LEN_W];
        nxt  = {1'b0, rd_addr} + (ADDR_W+1)'(len);
        c    = int'(arb_idx);
        if (st_q.ovld && ent_ready) st_d.ovld = 1'b0;
        if (frame_start) begin
            for (int i = 0; i < NCH; i++) begin
                st_d.busy[i] = cfg_en[i] && mode_walks(cfg_mode[2*i +: 2]);
                st_d.err[i]  = 1'b0;
                st_d.cur[i]  = cfg_ptr[i*ADDR_W +: ADDR_W];
            end
            st_d.last = CH_W'(NCH - 1);
        end else if (rd_go) begin
            st_d.last = arb_idx;
            if (rd_data[HDR_TERM_BIT]) begin
                st_d.busy[c] = 1'b0;
            end else if (len == '0 || nxt[ADDR_W]) begin
                st_d.busy[c] = 1'b0;
                st_d.err[c]  = 1'b1;
            end else begin
                st_d.ovld   = 1'b1;
                st_d.ochan  = arb_idx;
                st_d.oaddr  = rd_addr;
                st_d.olen   = len;
                st_d.ohdr   = rd_data;
                st_d.cur[c] = nxt[ADDR_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.last <= CH_W'(NCH - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign ent_valid = st_q.ovld;
    assign ent_chan  = st_q.ochan;
    assign ent_addr  = st_q.oaddr;
    assign ent_size  = st_q.olen;
    assign ent_hdr   = st_q.ohdr;
    assign chan_busy = st_q.busy;
    assign chan_err  = st_q.err;

    logic [ADDR_W:0] ent_end;
    assign ent_end = {1'b0, ent_addr} + (ADDR_W+1)'(ent_size);

    assert_hold_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid && !ent_ready |=> ent_valid && $stable(ent_addr)
            && $stable(ent_chan) && $stable(ent_hdr) && $stable(ent_size));

    assert_no_zero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> ent_size != '0);

    assert_in_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> ent_end < (ADDR_W+1)'(DEPTH));

    assert_grant_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |-> chan_busy[arb_idx]);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        assert_err_stops_R5: assert property (@(posedge clk) disable iff (!rst_n)
            chan_err[g] |-> !chan_busy[g]);
        assert_skip_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
            frame_start && !(cfg_en[g] && mode_walks(cfg_mode[2*g +: 2]))
                |=> !chan_busy[g]);
    end
endmodule

// File: tb/sim_dlist_walker.sv
module sim_dlist_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        frame_start = 1'b0;
    logic [2:0]  cfg_en = '0;
    logic [5:0]  cfg_mode = '0;
    logic [23:0] cfg_ptr = '0;
    logic        ent_valid;
    logic        ent_ready = 1'b0;
    logic [1:0]  ent_chan;
    logic [7:0]  ent_addr;
    logic [5:0]  ent_size;
    logic [31:0] ent_hdr;
    logic [2:0]  chan_busy;
    logic [2:0]  chan_err;

    always #5 clk = ~clk;

    dlist_walker u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .frame_start(frame_start), .cfg_en(cfg_en),
        .cfg_mode(cfg_mode), .cfg_ptr(cfg_ptr), .ent_valid(ent_valid),
        .ent_ready(ent_ready), .ent_chan(ent_chan), .ent_addr(ent_addr),
        .ent_size(ent_size), .ent_hdr(ent_hdr), .chan_busy(chan_busy),
        .chan_err(chan_err)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] shadow [256];
    logic [39:0] q0 [$];
    logic [39:0] q1 [$];
    logic [39:0] q2 [$];
    logic [2:0]  exp_err = '0;
    int          bp_mode = 0;
    logic [7:0]  lfsr = 8'hA5;
    int          xfer_cnt = 0;
    int          rec_n = 99;
    logic [1:0]  seq [6];
    string       cur_req = "R4";

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_hdr(input bit term, input int len, input int tag);
        return {term, 1'b0, 6'(len), 8'h00, 16'(tag)};
    endfunction

    // R9: every list word goes through the write port
    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 8'(a); wr_data = d;
        shadow[a] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_cfg(input int c, input bit en, input logic [1:0] md, input int p);
        cfg_en[c] = en;
        cfg_mode[2*c +: 2] = md;
        cfg_ptr[8*c +: 8] = 8'(p);
    endtask

    task automatic push_exp(input int c, input logic [39:0] v);
        case (c)
            0: q0.push_back(v);
            1: q1.push_back(v);
            default: q2.push_back(v);
        endcase
    endtask

    // Model walk from the requirements: R3 terminator, R4 hop, R5 zero, R6 bound.
    task automatic expect_chan(input int c, input int p);
        int a = p;
        exp_err[c] = 1'b0;
        for (int n = 0; n < 256; n++) begin
            int len;
            if (shadow[a][31]) break;
            len = int'(shadow[a][29:24]);
            if (len == 0 || a + len > 255) begin
                exp_err[c] = 1'b1;
                break;
            end
            push_exp(c, {8'(a), shadow[a]});
            a = a + len;
        end
    endtask

    task automatic frame();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while ((chan_busy != 0 || ent_valid) && n < 3000) begin
            @(negedge clk); n++;
        end
        chk(n < 3000, req, 64'(n), 64'd3000);
        @(negedge clk);
        chk(q0.size() == 0, req, 64'(q0.size()), 0);
        chk(q1.size() == 0, req, 64'(q1.size()), 0);
        chk(q2.size() == 0, req, 64'(q2.size()), 0);
        chk(chan_err == exp_err, req, 64'(chan_err), 64'(exp_err));
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    // Monitor: sets ready, then scores the transfer that the next edge completes.
    initial forever begin
        @(negedge clk);
        case (bp_mode)
            0: ent_ready = 1'b1;
            1: begin
                ent_ready = lfsr[0];
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            end
            default: ent_ready = 1'b0;
        endcase
        if (ent_valid && ent_ready) begin
            logic [39:0] e;
            bit have;
            xfer_cnt++;
            if (rec_n < 6) begin seq[rec_n] = ent_chan; rec_n++; end
            have = 1'b0;
            e = '0;
            case (ent_chan)
                2'd0: if (q0.size() > 0) begin e = q0.pop_front(); have = 1'b1; end
                2'd1: if (q1.size() > 0) begin e = q1.pop_front(); have = 1'b1; end
                2'd2: if (q2.size() > 0) begin e = q2.pop_front(); have = 1'b1; end
                default: have = 1'b0;
            endcase
            chk(have && e == {ent_addr, ent_hdr} && ent_size == ent_hdr[29:24],
                cur_req, {22'(ent_chan), ent_addr, ent_hdr, ent_size}, {24'h0, e});
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WATCHDOG", 0, 1);
        report();
    end

    initial begin
        for (int i = 0; i < 256; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(ent_valid == 1'b0, "R10", 64'(ent_valid), 0);
        chk(chan_busy == 3'b0, "R10", 64'(chan_busy), 0);
        chk(chan_err == 3'b0, "R10", 64'(chan_err), 0);
        rst_n = 1'b1;

        // Lists: ch0 at 32, ch1 at 64, ch2 at 100
        wr(32, mk_hdr(0, 3, 16'h0a01)); wr(35, mk_hdr(0, 5, 16'h0a02));
        wr(40, mk_hdr(0, 2, 16'h0a03)); wr(42, mk_hdr(1, 0, 16'h0aff));
        wr(64, mk_hdr(0, 4, 16'h0b01)); wr(68, mk_hdr(0, 1, 16'h0b02));
        wr(69, mk_hdr(0, 7, 16'h0b03)); wr(76, mk_hdr(1, 9, 16'h0bff));
        wr(100, mk_hdr(0, 2, 16'h0c01)); wr(102, mk_hdr(0, 2, 16'h0c02));
        wr(104, mk_hdr(0, 2, 16'h0c03)); wr(106, mk_hdr(0, 2, 16'h0c04));
        wr(108, mk_hdr(1, 0, 16'h0cff));

        // R4/R7: all three run, ready held high
        cur_req = "R4";
        bp_mode = 0;
        set_cfg(0, 1, 2'b01, 32); set_cfg(1, 1, 2'b01, 64); set_cfg(2, 1, 2'b01, 100);
        expect_chan(0, 32); expect_chan(1, 64); expect_chan(2, 100);
        rec_n = 0;
        frame();
        wait_idle("R4");
        for (int i = 0; i < 6; i++)
            chk(seq[i] == 2'(i % 3), "R7", 64'(seq[i]), 64'(i % 3));

        // R8: same frame under pseudo-random backpressure
        cur_req = "R8";
        bp_mode = 1;
        expect_chan(0, 32); expect_chan(1, 64); expect_chan(2, 100);
        frame();
        wait_idle("R8");

        // R2: ch0 run (2'b10), ch1 end-of-frame, ch2 disabled
        cur_req = "R2";
        bp_mode = 0;
        set_cfg(0, 1, 2'b10, 32); set_cfg(1, 1, 2'b11, 64); set_cfg(2, 0, 2'b01, 100);
        expect_chan(0, 32); exp_err[1] = 1'b0; exp_err[2] = 1'b0;
        frame();
        chk(chan_busy[0] == 1'b1, "R2", 64'(chan_busy), 64'h1);
        chk(chan_busy[1] == 1'b0, "R2", 64'(chan_busy), 64'h1);
        chk(chan_busy[2] == 1'b0, "R2", 64'(chan_busy), 64'h1);
        wait_idle("R2");

        // R3, R5, R6: immediate terminator, zero length, past the top
        cur_req = "R5";
        wr(120, mk_hdr(1, 3, 16'h0d00));
        wr(130, mk_hdr(0, 3, 16'h0e01)); wr(133, mk_hdr(0, 0, 16'h0e02));
        wr(250, mk_hdr(0, 5, 16'h0f01)); wr(255, mk_hdr(0, 2, 16'h0f02));
        set_cfg(0, 1, 2'b01, 120); set_cfg(1, 1, 2'b01, 130); set_cfg(2, 1, 2'b01, 250);
        expect_chan(0, 120); expect_chan(1, 130); expect_chan(2, 250);
        xfer_cnt = 0;
        frame();
        wait_idle("R6");
        chk(xfer_cnt == 2, "R3", 64'(xfer_cnt), 64'd2);
        chk(chan_err == 3'b110, "R5", 64'(chan_err), 64'h6);

        // R1: pointer change mid-frame ignored until next pulse; errors clear
        cur_req = "R1";
        bp_mode = 2;
        set_cfg(0, 1, 2'b01, 32); set_cfg(1, 0, 2'b00, 0); set_cfg(2, 0, 2'b00, 0);
        expect_chan(0, 32); exp_err[1] = 1'b0; exp_err[2] = 1'b0;
        frame();
        chk(chan_err == 3'b000, "R5", 64'(chan_err), 0);
        repeat (3) @(negedge clk);
        set_cfg(0, 1, 2'b01, 64);
        repeat (5) @(negedge clk);
        bp_mode = 0;
        wait_idle("R1");
        expect_chan(0, 64);
        frame();
        wait_idle("R1");

        // R9: rewrite the head of list 32 to a terminator
        cur_req = "R9";
        wr(32, mk_hdr(1, 0, 16'h1111));
        set_cfg(0, 1, 2'b01, 32);
        expect_chan(0, 32);
        xfer_cnt = 0;
        frame();
        wait_idle("R9");
        chk(xfer_cnt == 0, "R9", 64'(xfer_cnt), 0);

        report();
    end
endmodule